// File: doc/BRIEF.md
# Partitioned SIMD Fixed-Point Multiplier

This block multiplies two 64-bit operands with one partial-product array that can be set up three ways. In the wide setting it produces the full 128-bit product of the two words. In the dual-lane setting each operand is cut into a low and a high 32-bit lane. The two lane pairs are multiplied on their own, and each 64-bit lane product lands in the matching half of the 128-bit result. A third setting masks both operands down to 53 bits and multiplies them unsigned, which suits double-precision mantissas.

Signed operation uses no second multiplier. The array always forms the unsigned product of the (masked) operands. A correction term, taken from each operand's sign bit and the other operand, is then subtracted from the upper half of each product, and the result is reduced modulo that product's width. In dual-lane mode the array leaves out every partial product that would span the two lanes. Each lane's correction is also reduced inside its own 64 bits, so nothing passes from one lane to the other.

The result is registered. An operation presented with `inValid` high appears on `product` one clock later, with `outValid` high. The register keeps its value until the next valid operation.

Top module: `part_mul`

## Requirements
- R1: While `rstN` is low, and after it until the first valid operation, `outValid` is 0 and `product` is 0.
- R2: An operation accepted with `inValid` high at a rising edge appears on `product` with `outValid` high after that edge. In any cycle with `inValid` low, `outValid` drops and `product` keeps its previous value.
- R3: With `mode` = 0 and `signedOp` = 0, `product` is the full 128-bit unsigned product of `opA` and `opB`.
- R4: With `mode` = 0 and `signedOp` = 1, `product` is the 128-bit two's-complement product of `opA` and `opB`, both read as signed 64-bit values.
- R5: With `mode` = 1 and `signedOp` = 0, `product[63:0]` = `opA[31:0]` × `opB[31:0]` and `product[127:64]` = `opA[63:32]` × `opB[63:32]`, unsigned.
- R6: With `mode` = 1 and `signedOp` = 1, each lane is read as a signed 32-bit value whose sign is bit 31 of that lane (bits 31 and 63 of the operand). Each half of `product` holds that lane's 64-bit two's-complement product.
- R7: In mode 1 a lane's result depends only on that lane's operands. Changing the low lanes leaves `product[127:64]` unchanged.
- R8: With `mode` = 2, `product` = `opA[52:0]` × `opB[52:0]` unsigned. Operand bits 63..53 and `signedOp` have no effect, and `product[127:106]` is 0.
- R9: `mode` = 3 is reserved and behaves exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present on the operand inputs |
| mode | input | 2 | 0 wide, 1 dual 32-bit lanes, 2 53-bit mantissa, 3 reserved (as 0) |
| signedOp | input | 1 | 1 reads operands as two's complement (modes 0, 1, 3) |
| opA | input | 64 | Multiplicand |
| opB | input | 64 | Multiplier |
| outValid | output | 1 | `product` was loaded by the previous cycle's operation |
| product | output | 128 | Registered result |

## Verification
The bound assertions watch, on every cycle, the handshake timing and the hold of the result between operations. They also check that the mantissa result stays inside 106 bits, that a zero operand gives a zero result outside dual mode, and that an unsigned dual operation with a zero high lane leaves the upper half zero. The numerical value of each mode is left to the bench. It compares every product against a separately written model for table vectors, random operands and the all-ones, most-negative and zero corners, and it shows lane isolation by re-running with only the low lanes changed.

// File: rtl/part_mul_pkg.sv
package part_mul_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE = 2'd0,
    MODE_DUAL = 2'd1,
    MODE_MANT = 2'd2,
    MODE_RSVD = 2'd3
  } mulMode_e;

  typedef struct packed {
    logic split;     // cut the array into two lanes
    logic mantMask;  // clear operand bits above the mantissa
    logic signCorr;  // apply sign-bit correction
    logic load;      // capture result
  } mulStrb_t;
endpackage

// File: rtl/part_mul_ctrl.sv
module part_mul_ctrl
  import part_mul_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] mode,
  input  logic       signedOp,
  output mulStrb_t   strb,
  output logic       outValid
);
  mulMode_e modeDec;

  always_comb begin
    modeDec = mulMode_e'(mode);
    strb = '0;
    strb.load = inValid;
    unique case (modeDec)
      MODE_DUAL: begin
        strb.split    = 1'b1;
        strb.signCorr = signedOp;
      end
      MODE_MANT: begin
        strb.mantMask = 1'b1;
        strb.signCorr = 1'b0;
      end
      default: begin
        strb.signCorr = signedOp;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/part_mul_dp.sv
module part_mul_dp
  import part_mul_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int MANT_W = 53
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mulStrb_t              strb,
  input  logic [2*LANE_W-1:0]   opA,
  input  logic [2*LANE_W-1:0]   opB,
  output logic [4*LANE_W-1:0]   product
);
  localparam int WORD_W = 2 * LANE_W;
  localparam int PROD_W = 2 * WORD_W;
  localparam int LANES  = 2;
  localparam logic [WORD_W-1:0] MANT_MSK = {{(WORD_W-MANT_W){1'b0}}, {MANT_W{1'b1}}};
  localparam logic [WORD_W-1:0] LO_MSK   = {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
  localparam logic [WORD_W-1:0] HI_MSK   = {{LANE_W{1'b1}}, {LANE_W{1'b0}}};

  logic [WORD_W-1:0] aEff, bEff;
  logic [PROD_W-1:0] arrSum;
  logic [WORD_W-1:0] wideCorr;
  logic [WORD_W-1:0] laneRes [LANES];
  logic [PROD_W-1:0] nextProd;

  // Operand conditioning for the mantissa path
  assign aEff = strb.mantMask ? (opA & MANT_MSK) : opA;
  assign bEff = strb.mantMask ? (opB & MANT_MSK) : opB;

  // Shared unsigned partial-product array; cross-lane rows masked in split mode
  always_comb begin
    logic [WORD_W-1:0] rowMsk;
    arrSum = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (strb.split) rowMsk = (i < LANE_W) ? LO_MSK : HI_MSK;
      else            rowMsk = '1;
      if (bEff[i])
        arrSum = arrSum + ({{WORD_W{1'b0}}, aEff & rowMsk} << i);
    end
  end

  // Sign-bit correction for the full-width product (upper half only)
  always_comb begin
    logic sA, sB;
    sA = strb.signCorr & aEff[WORD_W-1];
    sB = strb.signCorr & bEff[WORD_W-1];
    wideCorr = (sA ? bEff : '0) + (sB ? aEff : '0);
  end

  // Per-lane sign correction, each reduced inside its own lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] aL, bL;
    logic [WORD_W-1:0] corr;
    logic sA, sB;
    assign aL = aEff[k*LANE_W +: LANE_W];
    assign bL = bEff[k*LANE_W +: LANE_W];
    assign sA = strb.signCorr & aL[LANE_W-1];
    assign sB = strb.signCorr & bL[LANE_W-1];
    assign corr = {(sA ? bL : '0) + (sB ? aL : '0), {LANE_W{1'b0}}};
    assign laneRes[k] = arrSum[k*WORD_W +: WORD_W] - corr;
  end

  always_comb begin
    if (strb.split)
      nextProd = {laneRes[1], laneRes[0]};
    else
      nextProd = {arrSum[PROD_W-1:WORD_W] - wideCorr, arrSum[WORD_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)          product <= '0;
    else if (strb.load) product <= nextProd;
  end
endmodule

// File: rtl/part_mul.sv
module part_mul
  import part_mul_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int MANT_W = 53
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          mode,
  input  logic                signedOp,
  input  logic [2*LANE_W-1:0] opA,
  input  logic [2*LANE_W-1:0] opB,
  output logic                outValid,
  output logic [4*LANE_W-1:0] product
);
  mulStrb_t strb;

  part_mul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .signedOp(signedOp), .strb(strb), .outValid(outValid)
  );

  part_mul_dp #(.LANE_W(LANE_W), .MANT_W(MANT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .product(product)
  );
endmodule

// File: rtl/part_mul_chk.sv
module part_mul_chk (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [1:0]   mode,
  input logic         signedOp,
  input logic [63:0]  opA,
  input logic [63:0]  opB,
  input logic         outValid,
  input logic [127:0] product
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(product)));  // R2

  AST_MANT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'd2) |=> (product[127:106] == '0));  // R8

  AST_ZERO_OPND: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode != 2'd1 && (opA == '0 || opB == '0)) |=> (product == '0));  // R3

  AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'd1 && !signedOp && opA[63:32] == '0) |=> (product[127:64] == '0));  // R7
endmodule

bind part_mul part_mul_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .signedOp(signedOp),
  .opA(opA), .opB(opB), .outValid(outValid), .product(product)
);

// File: tb/sim_part_mul.sv
module sim_part_mul;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         signedOp = 1'b0;
  logic [63:0]  opA = '0;
  logic [63:0]  opB = '0;
  logic         outValid;
  logic [127:0] product;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  part_mul u0 (.*);

  // {mode, signed, a, b}
  localparam int NVEC = 12;
  localparam logic [130:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd0, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0007},
    {2'd0, 1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
    {2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd1, 1'b1, 64'h8000_0000_8000_0000, 64'h8000_0000_7FFF_FFFF},
    {2'd1, 1'b1, 64'hFFFF_FFFF_0000_0003, 64'h0000_0005_FFFF_FFFF},
    {2'd1, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321},
    {2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd2, 1'b1, 64'hFFF0_0000_0000_0001, 64'h001F_FFFF_FFFF_FFFF},
    {2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0003},
    {2'd0, 1'b0, 64'h0000_0000_0000_0000, 64'hDEAD_BEEF_0000_0001}
  };

  function automatic logic [127:0] model(input logic [1:0] m, input logic s,
                                         input logic [63:0] a, input logic [63:0] b);
    logic [127:0] r;
    logic signed [127:0] sa, sb;
    logic signed [63:0] la, lb;
    logic [63:0] lo, hi;
    logic [63:0] ma, mb;
    case (m)
      2'd1: begin
        if (s) begin
          la = $signed({{32{a[31]}}, a[31:0]}); lb = $signed({{32{b[31]}}, b[31:0]});
          lo = 64'(la * lb);
          la = $signed({{32{a[63]}}, a[63:32]}); lb = $signed({{32{b[63]}}, b[63:32]});
          hi = 64'(la * lb);
        end else begin
          lo = {32'd0, a[31:0]} * {32'd0, b[31:0]};
          hi = {32'd0, a[63:32]} * {32'd0, b[63:32]};
        end
        r = {hi, lo};
      end
      2'd2: begin
        ma = {11'd0, a[52:0]}; mb = {11'd0, b[52:0]};
        r = {64'd0, ma} * {64'd0, mb};
      end
      default: begin
        if (s) begin
          sa = $signed({{64{a[63]}}, a}); sb = $signed({{64{b[63]}}, b});
          r = 128'(sa * sb);
        end else begin
          r = {64'd0, a} * {64'd0, b};
        end
      end
    endcase
    return r;
  endfunction

  function automatic string reqOf(input logic [1:0] m, input logic s);
    case (m)
      2'd1: return s ? "R6" : "R5";
      2'd2: return "R8";
      2'd3: return "R9";
      default: return s ? "R4" : "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] m, input logic s,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    mode = m; signedOp = s; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(reqOf(m, s), product, model(m, s, a, b));
    check("R2", {127'd0, outValid}, 128'd1);
  endtask

  logic [127:0] keep;

  initial begin
    repeat (3) @(negedge clk);
    check("R1", product, '0);
    check("R1", {127'd0, outValid}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", product, '0);
    check("R1", {127'd0, outValid}, 128'd0);

    for (int i = 0; i < NVEC; i++)
      runOp(VEC[i][130:129], VEC[i][128], VEC[i][127:64], VEC[i][63:0]);

    // R2: hold while idle, even with inputs moving
    runOp(2'd0, 1'b0, 64'h0000_0001_0000_0003, 64'h0000_0000_0000_0005);
    keep = product;
    opA = 64'hAAAA_AAAA_AAAA_AAAA; opB = 64'h5555_5555_5555_5555; mode = 2'd1;
    @(negedge clk);
    check("R2", product, keep);
    check("R2", {127'd0, outValid}, 128'd0);

    // R7: low lanes changed, high lane result unchanged
    runOp(2'd1, 1'b1, 64'h8765_4321_0000_0000, 64'hF000_000F_0000_0000);
    keep = product;
    runOp(2'd1, 1'b1, 64'h8765_4321_FFFF_FFFF, 64'hF000_000F_8000_0000);
    check("R7", {64'd0, product[127:64]}, {64'd0, keep[127:64]});
    runOp(2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF);
    check("R7", {64'd0, product[127:64]}, 128'h0000_0000_0000_0000_0000_0000_FFFF_FFFF);

    // R8: signedOp and upper bits ignored in mantissa mode
    runOp(2'd2, 1'b0, 64'h001A_BCDE_F012_3456, 64'h0013_5792_4680_ACE1);
    keep = product;
    runOp(2'd2, 1'b1, 64'hFFFA_BCDE_F012_3456, 64'h8013_5792_4680_ACE1);
    check("R8", product, keep);

    // R9: reserved mode matches mode 0
    runOp(2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);

    // Random sweep of every mode and signedness
    for (int i = 0; i < 200; i++)
      runOp(2'(i % 4), 1'((i / 4) % 2), {$urandom, $urandom}, {$urandom, $urandom});

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule